// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block models the control logic of a 16-bit parallel NOR flash. It watches an asynchronous-style memory bus (active-low chip enable, write enable and output enable, an address and a data word) by sampling it on the system clock. A write is accepted when the write strobe ends. Keyed unlock sequences arrive as a series of such writes and start one of these operations: word program, sector erase, chip erase, boot-region lockout, or entry to and exit from an identification mode. Program and erase then run for a configurable number of clock cycles. During that time the read path returns progress status instead of array contents.

The array is a small register memory. There are four regions: boot, two parameter regions and the main region. Each region keeps a window of `2**WIN_W` words, selected by the low address bits, so addresses inside a region that differ only above the window alias to the same word. The lockout is sticky until a cold reset. It protects the boot region and changes which regions a main-sector erase clears.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: While `cold_rst_n` is low, every array word becomes FFFFh, the lockout clears and the block returns to read mode; `rst_n` low does the same except that the array and the lockout are kept.
- R2: `dout_en` is 1 only when `ce_n`=0, `oe_n`=0 and `we_n`=1 (and no reset is active); otherwise `dout_en`=0 and `dout`=0. A write is accepted on the clock after `ce_n`=0,`we_n`=0,`oe_n`=1 ends, using the last address and data sampled while it was active.
- R3: Every command begins with AAh at address 5555h, then 55h at 2AAAh. Only address bits 14..0 and data bits 7..0 are compared; data bits 15..8 are ignored.
- R4: Third write A0h at 5555h makes the fourth write a program. After `PGM_CYC` cycles the word becomes old AND new (bits can only clear). The word index is the region (address bits 17..13: 0 boot, 1 parameter 1, 2 parameter 2, otherwise main) joined with address bits `WIN_W-1..0`.
- R5: While an operation is busy, a read returns a status word: bit 7 is the inverse of bit 7 of the data being programmed (0 during an erase), bit 6 starts at 0 and inverts after each completed read, and all other bits are 0.
- R6: Every write that completes while an operation is busy is ignored.
- R7: In identification mode (third write 90h at 5555h), reads return 001Fh at address 0, 0092h at address 1, the lockout flag on bit 0 at address 2, and 0000h elsewhere.
- R8: A write of F0h to any address leaves identification mode and abandons a partial sequence, except when F0h is the data word of a program.
- R9: A write that does not match the expected step returns the sequencer to its idle state without side effects.
- R10: After the 80h/AAh/55h extension, a sixth write of 30h erases the sector given by address bits 17..12 after `ERS_CYC` cycles: 03h selects parameter 1, 05h selects parameter 2, and 3Fh selects main together with boot when unlocked. Any other value erases nothing.
- R11: A sixth write of 10h at 5555h erases every region to FFFFh, unless the lockout is set, in which case it is ignored.
- R12: A sixth write of 40h at 5555h sets the lockout. Once set, a program aimed at the boot region has no effect, a main-sector erase leaves boot intact, and the flag stays set until cold reset.
- R13: `rst_n` low aborts a busy operation, leaving the targeted words unchanged; it forces `dout_en` to 0 and returns to read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Warm reset, active low; keeps array and lockout |
| cold_rst_n | input | 1 | Cold reset, active low; erases array, clears lockout |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data or busy status |
| dout_en | output | 1 | High when `dout` should be driven |

## Verification
The bench builds the block with `PGM_CYC`=40, `ERS_CYC`=70 and `WIN_W`=4. These busy windows are long enough to fit a whole three-write command and several completed reads inside one program or erase. That makes the ignored-write rule and several steps of the bit-6 toggle observable, and lets a warm reset land mid-operation. A 16-word window per region keeps the array at 64 words, which the reference model can mirror exactly. The window also lets aliasing and each region's erase boundary be checked word by word.

// File: rtl/nor_pkg.sv
package nor_pkg;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_K1, SQ_K2, SQ_PDATA, SQ_X0, SQ_X1, SQ_X2, SQ_BPGM, SQ_BERS
  } seq_t;

  localparam logic [14:0] KEY_A = 15'h5555;
  localparam logic [14:0] KEY_B = 15'h2AAA;

  localparam logic [7:0] C_UNLK1 = 8'hAA;
  localparam logic [7:0] C_UNLK2 = 8'h55;
  localparam logic [7:0] C_PROG  = 8'hA0;
  localparam logic [7:0] C_IDIN  = 8'h90;
  localparam logic [7:0] C_EXT   = 8'h80;
  localparam logic [7:0] C_EXIT  = 8'hF0;
  localparam logic [7:0] C_CHIP  = 8'h10;
  localparam logic [7:0] C_SECT  = 8'h30;
  localparam logic [7:0] C_LOCK  = 8'h40;

  localparam logic [15:0] ID_MFR = 16'h001F;
  localparam logic [15:0] ID_DEV = 16'h0092;

  localparam int NREG = 4;
  localparam logic [1:0] RG_BOOT = 2'd0;
  localparam logic [1:0] RG_P1   = 2'd1;
  localparam logic [1:0] RG_P2   = 2'd2;
  localparam logic [1:0] RG_MAIN = 2'd3;

  // hi = address bits above 8K-word granule
  function automatic logic [1:0] region_of(input logic [31:0] hi);
    if (hi == 32'd0)      return RG_BOOT;
    else if (hi == 32'd1) return RG_P1;
    else if (hi == 32'd2) return RG_P2;
    else                  return RG_MAIN;
  endfunction

endpackage

// File: rtl/nor_rst_sync.sv
module nor_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s1;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1     <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      s1     <= 1'b1;
      srst_n <= s1;
    end
  end
endmodule

// File: rtl/nor_strobe.sv
module nor_strobe #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              wr_done,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_act,
  output logic              rd_end
);
  logic wr_act, wr_q, rd_q;

  assign wr_act = !ce_n && !we_n && oe_n;
  assign rd_act = !ce_n && !oe_n && we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_act) begin
        wr_addr <= addr;
        wr_data <= din;
      end
    end
  end

  assign wr_done = wr_q && !wr_act;
  assign rd_end  = rd_q && !rd_act;
endmodule

// File: rtl/nor_seq.sv
module nor_seq
  import nor_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int WIN_W   = 4,
  parameter int PGM_CYC = 8,
  parameter int ERS_CYC = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cold_n,
  input  logic                 wr_done,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 rd_end,
  output logic                 busy,
  output logic                 stat7,
  output logic                 tog,
  output logic                 idm,
  output logic                 lock,
  output logic                 pgm_go,
  output logic [WIN_W+1:0]     pgm_idx,
  output logic [DATA_W-1:0]    pgm_data,
  output logic                 ers_go,
  output logic [NREG-1:0]      ers_mask
);
  localparam int IW   = WIN_W + 2;
  localparam int MAXC = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int SW   = ADDR_W - 12;

  seq_t            st, st_n;
  logic [CW-1:0]   cnt, cnt_n;
  logic [IW-1:0]   pa_n;
  logic [DATA_W-1:0] pd_n;
  logic [NREG-1:0] mask_n, sec_mask;
  logic            lock_n, idm_n, tog_n;
  logic [7:0]      k;
  logic            at_a, at_b;
  logic [SW-1:0]   sec;
  logic [1:0]      w_reg;

  assign k     = wr_data[7:0];
  assign at_a  = (wr_addr[14:0] == KEY_A);
  assign at_b  = (wr_addr[14:0] == KEY_B);
  assign sec   = wr_addr[ADDR_W-1:12];
  assign w_reg = region_of(32'(wr_addr[ADDR_W-1:13]));

  always_comb begin
    sec_mask = '0;
    if (sec == SW'(3))      sec_mask = 4'b0010;
    else if (sec == SW'(5)) sec_mask = 4'b0100;
    else if (&sec)          sec_mask = {1'b1, 2'b00, !lock};
  end

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    pa_n   = pgm_idx;
    pd_n   = pgm_data;
    mask_n = ers_mask;
    lock_n = lock;
    idm_n  = idm;
    tog_n  = tog;
    pgm_go = 1'b0;
    ers_go = 1'b0;
    case (st)
      SQ_BPGM, SQ_BERS: begin
        if (rd_end) tog_n = !tog;
        if (cnt == '0) begin
          st_n   = SQ_IDLE;
          pgm_go = (st == SQ_BPGM);
          ers_go = (st == SQ_BERS);
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      default: begin
        if (wr_done) begin
          st_n = SQ_IDLE;
          if (k == C_EXIT && st != SQ_PDATA) begin
            idm_n = 1'b0;
          end else begin
            case (st)
              SQ_IDLE: if (at_a && k == C_UNLK1) st_n = SQ_K1;
              SQ_K1:   if (at_b && k == C_UNLK2) st_n = SQ_K2;
              SQ_K2: if (at_a) begin
                if (k == C_PROG)      st_n  = SQ_PDATA;
                else if (k == C_IDIN) idm_n = 1'b1;
                else if (k == C_EXT)  st_n  = SQ_X0;
              end
              SQ_PDATA: if (!(lock && w_reg == RG_BOOT)) begin
                st_n  = SQ_BPGM;
                cnt_n = CW'(PGM_CYC - 1);
                pa_n  = {w_reg, wr_addr[WIN_W-1:0]};
                pd_n  = wr_data;
                tog_n = 1'b0;
              end
              SQ_X0: if (at_a && k == C_UNLK1) st_n = SQ_X1;
              SQ_X1: if (at_b && k == C_UNLK2) st_n = SQ_X2;
              SQ_X2: begin
                if (at_a && k == C_CHIP) begin
                  if (!lock) begin
                    st_n   = SQ_BERS;
                    cnt_n  = CW'(ERS_CYC - 1);
                    mask_n = '1;
                    tog_n  = 1'b0;
                  end
                end else if (at_a && k == C_LOCK) begin
                  lock_n = 1'b1;
                end else if (k == C_SECT && sec_mask != '0) begin
                  st_n   = SQ_BERS;
                  cnt_n  = CW'(ERS_CYC - 1);
                  mask_n = sec_mask;
                  tog_n  = 1'b0;
                end
              end
              default: st_n = SQ_IDLE;
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      cnt      <= '0;
      pgm_idx  <= '0;
      pgm_data <= '0;
      ers_mask <= '0;
      idm      <= 1'b0;
      tog      <= 1'b0;
    end else begin
      st       <= st_n;
      cnt      <= cnt_n;
      pgm_idx  <= pa_n;
      pgm_data <= pd_n;
      ers_mask <= mask_n;
      idm      <= idm_n;
      tog      <= tog_n;
    end
  end

  always_ff @(posedge clk or negedge cold_n) begin
    if (!cold_n) lock <= 1'b0;
    else         lock <= lock_n;
  end

  assign busy  = (st == SQ_BPGM) || (st == SQ_BERS);
  assign stat7 = (st == SQ_BPGM) ? !pgm_data[7] : 1'b0;

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (busy && $stable(pgm_idx) && $stable(pgm_data) && $stable(lock) && $stable(idm)));

  // R12
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!cold_n)
    lock |=> lock);
endmodule

// File: rtl/nor_array.sv
module nor_array
  import nor_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WIN_W  = 4
) (
  input  logic               clk,
  input  logic               cold_n,
  input  logic               pgm_go,
  input  logic [WIN_W+1:0]   pgm_idx,
  input  logic [DATA_W-1:0]  pgm_data,
  input  logic               ers_go,
  input  logic [NREG-1:0]    ers_mask,
  input  logic [WIN_W+1:0]   rd_idx,
  output logic [DATA_W-1:0]  rd_data
);
  localparam int IW = WIN_W + 2;
  localparam int NW = 1 << IW;

  logic [DATA_W-1:0] mem [NW];

  always_ff @(posedge clk or negedge cold_n) begin
    if (!cold_n) begin
      for (int i = 0; i < NW; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < NW; i++) begin
        if (ers_go && ers_mask[2'(i >> WIN_W)])
          mem[i] <= '1;
        else if (pgm_go && pgm_idx == IW'(i))
          mem[i] <= mem[i] & pgm_data;
      end
    end
  end

  assign rd_data = mem[rd_idx];

  logic              chk_go;
  logic [IW-1:0]     chk_idx;
  logic [DATA_W-1:0] chk_dat;

  always_ff @(posedge clk or negedge cold_n) begin
    if (!cold_n) begin
      chk_go  <= 1'b0;
      chk_idx <= '0;
      chk_dat <= '0;
    end else begin
      chk_go  <= pgm_go;
      chk_idx <= pgm_idx;
      chk_dat <= pgm_data;
    end
  end

  // R4
  pgm_clear_only_chk: assert property (@(posedge clk) disable iff (!cold_n)
    chk_go |-> ((mem[chk_idx] & ~chk_dat) == '0));
endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int WIN_W   = 4,
  parameter int PGM_CYC = 8,
  parameter int ERS_CYC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cold_rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int IW = WIN_W + 2;

  logic cold_n, warm_n, warm_raw;
  logic wr_done, rd_act, rd_end;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data, pgm_data, rd_data;
  logic busy, stat7, tog, idm, lock, pgm_go, ers_go;
  logic [IW-1:0] pgm_idx, rd_idx;
  logic [NREG-1:0] ers_mask;

  assign warm_raw = rst_n && cold_rst_n;

  nor_rst_sync u_cold (.clk(clk), .arst_n(cold_rst_n), .srst_n(cold_n));
  nor_rst_sync u_warm (.clk(clk), .arst_n(warm_raw),   .srst_n(warm_n));

  nor_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
    .clk(clk), .rst_n(warm_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .wr_done(wr_done), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_act(rd_act), .rd_end(rd_end)
  );

  nor_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_W(WIN_W),
    .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC)
  ) u_seq (
    .clk(clk), .rst_n(warm_n), .cold_n(cold_n), .wr_done(wr_done),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_end(rd_end),
    .busy(busy), .stat7(stat7), .tog(tog), .idm(idm), .lock(lock),
    .pgm_go(pgm_go), .pgm_idx(pgm_idx), .pgm_data(pgm_data),
    .ers_go(ers_go), .ers_mask(ers_mask)
  );

  assign rd_idx = {region_of(32'(addr[ADDR_W-1:13])), addr[WIN_W-1:0]};

  nor_array #(.DATA_W(DATA_W), .WIN_W(WIN_W)) u_array (
    .clk(clk), .cold_n(cold_n), .pgm_go(pgm_go), .pgm_idx(pgm_idx),
    .pgm_data(pgm_data), .ers_go(ers_go), .ers_mask(ers_mask),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  assign dout_en = warm_n && rd_act;

  always_comb begin
    dout = '0;
    if (dout_en) begin
      if (busy) begin
        dout[7] = stat7;
        dout[6] = tog;
      end else if (idm) begin
        if (addr == ADDR_W'(0))      dout = DATA_W'(ID_MFR);
        else if (addr == ADDR_W'(1)) dout = DATA_W'(ID_DEV);
        else if (addr == ADDR_W'(2)) dout = DATA_W'(lock);
      end else begin
        dout = rd_data;
      end
    end
  end

  // R12
  boot_erase_guard_chk: assert property (@(posedge clk) disable iff (!warm_n)
    ers_go |-> !(lock && ers_mask[0]));

  // R12
  boot_pgm_guard_chk: assert property (@(posedge clk) disable iff (!warm_n)
    pgm_go |-> !(lock && pgm_idx[IW-1 -: 2] == RG_BOOT));
endmodule

// File: tb/nor_cmd_ctrl_test.sv
module nor_cmd_ctrl_test;
  localparam int PGM = 40;
  localparam int ERS = 70;
  localparam int WIN = 4;
  localparam int NWM = 1 << (WIN + 2);

  logic        clk = 1'b0;
  logic        rst_n, cold_rst_n, ce_n, we_n, oe_n;
  logic [17:0] addr;
  logic [15:0] din, dout;
  logic        dout_en;

  nor_cmd_ctrl #(.ADDR_W(18), .DATA_W(16), .WIN_W(WIN), .PGM_CYC(PGM), .ERS_CYC(ERS)) uut (
    .clk(clk), .rst_n(rst_n), .cold_rst_n(cold_rst_n), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  always #10 clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit checking = 0, done = 0;
  string cur_req = "R1";

  // reference model state
  int m_mem[NWM];
  bit wp, rp, idm, lk, bk_pgm, tg;
  int cap_a, cap_d, step, bl, pa, pd, em;

  function automatic int ridx(int a);
    int r = a >> 13;
    if (r > 2) r = 3;
    return r * 16 + (a & 15);
  endfunction

  task automatic m_clear();
    wp = 0; rp = 0; idm = 0; step = 0; bl = 0; tg = 0; cap_a = 0; cap_d = 0;
  endtask

  always @(posedge clk) begin
    bit wa, ra, cm;
    int k, a15, s;
    if (!cold_rst_n) begin
      lk = 0;
      foreach (m_mem[i]) m_mem[i] = 'hFFFF;
      m_clear();
    end else if (!rst_n) begin
      m_clear();
    end else begin
      wa = !ce_n && !we_n && oe_n;
      ra = !ce_n && !oe_n && we_n;
      cm = wp && !wa;
      if (bl > 0) begin
        if (rp && !ra) tg = !tg;
        bl--;
        if (bl == 0) begin
          if (bk_pgm) m_mem[pa] = m_mem[pa] & pd;
          else foreach (m_mem[i]) if (em[i / 16]) m_mem[i] = 'hFFFF;
        end
      end else if (cm) begin
        k = cap_d & 'hFF;
        a15 = cap_a & 'h7FFF;
        if (step == 4) begin
          step = 0;
          if (!(lk && (cap_a >> 13) == 0)) begin
            bl = PGM; bk_pgm = 1; pa = ridx(cap_a); pd = cap_d; tg = 0;
          end
        end else if (k == 'hF0) begin
          step = 0; idm = 0;
        end else begin
          case (step)
            0: step = (a15 == 'h5555 && k == 'hAA) ? 1 : 0;
            1: step = (a15 == 'h2AAA && k == 'h55) ? 2 : 0;
            2: begin
              step = 0;
              if (a15 == 'h5555) begin
                if (k == 'hA0) step = 4;
                else if (k == 'h90) idm = 1;
                else if (k == 'h80) step = 5;
              end
            end
            5: step = (a15 == 'h5555 && k == 'hAA) ? 6 : 0;
            6: step = (a15 == 'h2AAA && k == 'h55) ? 7 : 0;
            7: begin
              step = 0;
              if (a15 == 'h5555 && k == 'h10) begin
                if (!lk) begin bl = ERS; bk_pgm = 0; em = 15; tg = 0; end
              end else if (a15 == 'h5555 && k == 'h40) begin
                lk = 1;
              end else if (k == 'h30) begin
                s = cap_a >> 12;
                if (s == 3) em = 2;
                else if (s == 5) em = 4;
                else if (s == 'h3F) em = lk ? 8 : 9;
                else em = 0;
                if (em != 0) begin bl = ERS; bk_pgm = 0; tg = 0; end
              end
            end
            default: step = 0;
          endcase
        end
      end
      wp = wa;
      rp = ra;
      if (wa) begin cap_a = int'(addr); cap_d = int'(din); end
    end
  end

  always @(negedge clk) begin
    bit ee;
    int ed;
    #2;
    if (checking) begin
      ee = rst_n && cold_rst_n && !ce_n && !oe_n && we_n;
      ed = 0;
      if (ee) begin
        if (bl > 0)       ed = (bk_pgm ? (((~pd) >> 7) & 1) << 7 : 0) | (int'(tg) << 6);
        else if (idm)     ed = (addr == 0) ? 'h1F : (addr == 1) ? 'h92 : (addr == 2) ? int'(lk) : 0;
        else              ed = m_mem[ridx(int'(addr))];
      end
      vectors++;
      if (dout_en !== ee || int'(dout) != ed || $isunknown(dout)) begin
        miscompares++;
        $display("FAIL %s at %0t: got en=%0b dout=%h, expected en=%0b dout=%h",
                 cur_req, $time, dout_en, dout, ee, ed[15:0]);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 18'(a); din = 16'(d); ce_n = 0; we_n = 0; oe_n = 1;
    @(negedge clk);
    @(negedge clk);
    we_n = 1; ce_n = 1;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    addr = 18'(a); ce_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk);
    ce_n = 1; oe_n = 1;
  endtask

  task automatic pins(input bit c, input bit o, input bit w);
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w;
    @(negedge clk);
    ce_n = 1; oe_n = 1; we_n = 1;
  endtask

  task automatic pgm(input int a, input int d);
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'hA0); wr(a, d);
  endtask

  task automatic ext6(input int a, input int d);
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'h80);
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr(a, d);
  endtask

  task automatic warm_reset();
    @(negedge clk); rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(4);
  endtask

  initial begin
    rst_n = 0; cold_rst_n = 0; ce_n = 1; we_n = 1; oe_n = 1; addr = '0; din = '0;
    idle(3);
    checking = 1;
    cur_req = "R1";
    rd(0);
    idle(1);
    cold_rst_n = 1; rst_n = 1;
    idle(4);
    rd(0); rd('h3F00F); rd('h02003);

    cur_req = "R2";
    pins(1, 0, 1); pins(0, 1, 1); pins(0, 0, 0);
    rd('h06005);

    cur_req = "R4";
    pgm('h06005, 'h1234);
    cur_req = "R5";
    rd('h06005); rd(0); rd('h06005);
    idle(PGM);
    cur_req = "R4";
    rd('h06005); rd('h06015);
    pgm('h06015, 'hFF0F);
    idle(PGM + 2);
    rd('h06005);

    cur_req = "R3";
    wr('h5555, 'h12AA); wr('h2AAA, 'hFF55); wr('hD555, 'h00A0); wr('h02003, 'hBEEF);
    idle(PGM + 2);
    rd('h02003);

    cur_req = "R6";
    pgm('h04002, 'h0F0F);
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'h90);
    rd(0);
    idle(PGM);
    rd(0); rd('h04002);

    cur_req = "R7";
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'h90);
    rd(0); rd(1); rd(2); rd(3);
    cur_req = "R8";
    wr('h12345, 'hF0);
    rd(0);
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'h90);
    rd(1);
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'hF0);
    rd(1);
    wr('h5555, 'hAA); wr('h2AAA, 'hF0); wr('h5555, 'hA0); wr('h06005, 'h0000);
    idle(4);
    rd('h06005);
    pgm('h06007, 'h00F0);
    idle(PGM + 2);
    rd('h06007);

    cur_req = "R9";
    wr('h5555, 'hAA); wr('h1234, 'h55); wr('h5555, 'hA0); wr('h06005, 'h0000);
    idle(4);
    rd('h06005);
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5554, 'hA0); wr('h06005, 'h0000);
    idle(4);
    rd('h06005);

    cur_req = "R10";
    pgm('h00007, 'h00FF);
    idle(PGM + 2);
    ext6('h03000, 'h30);
    cur_req = "R5";
    rd('h02003); rd('h02003); rd('h02003);
    idle(ERS);
    cur_req = "R10";
    rd('h02003); rd('h00007); rd('h04002);
    ext6('h05ABC, 'h30);
    idle(ERS + 2);
    rd('h04002); rd('h06005);
    ext6('h10000, 'h30);
    idle(ERS + 2);
    rd('h06005);
    ext6('h3F123, 'h30);
    idle(ERS + 2);
    rd('h06005); rd('h00007);

    cur_req = "R11";
    pgm('h00001, 'h1111); idle(PGM + 2);
    pgm('h02001, 'h2222); idle(PGM + 2);
    pgm('h3FFF1, 'h3333); idle(PGM + 2);
    rd('h00001); rd('h3FFF1);
    ext6('h5555, 'h10);
    rd(0);
    idle(ERS + 2);
    rd('h00001); rd('h02001); rd('h3FFF1);

    cur_req = "R13";
    pgm('h06009, 'h0000);
    idle(5);
    @(negedge clk); addr = 18'h06009; ce_n = 0; oe_n = 0; rst_n = 0;
    @(negedge clk); ce_n = 1; oe_n = 1;
    idle(2);
    rst_n = 1;
    idle(4);
    rd('h06009);
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'h90);
    warm_reset();
    rd(0);

    cur_req = "R12";
    pgm('h00003, 'h5A5A); idle(PGM + 2);
    pgm('h06003, 'hA5A5); idle(PGM + 2);
    ext6('h5555, 'h40);
    idle(2);
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'h90);
    rd(2);
    wr(0, 'hF0);
    pgm('h00003, 'h0000);
    idle(PGM + 2);
    rd('h00003);
    cur_req = "R11";
    ext6('h5555, 'h10);
    idle(4);
    rd('h06003); rd('h00003);
    cur_req = "R12";
    ext6('h3F000, 'h30);
    idle(ERS + 2);
    rd('h06003); rd('h00003);
    warm_reset();
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'h90);
    rd(2);
    wr(0, 'hF0);

    cur_req = "R1";
    @(negedge clk); cold_rst_n = 0;
    idle(3);
    cold_rst_n = 1;
    idle(4);
    rd('h00003);
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'h90);
    rd(2);
    idle(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got still running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule